// File: doc/BRIEF.md
# E1 Timeslot Source Selector

This block sits in the serial transmit path of a 2.048 Mbit/s E1 link and decides, bit by bit, what leaves on the line for each of the 32 eight-bit timeslots of a frame. It runs on the transmit bit clock. A frame-sync pulse marks the first bit of timeslot 1. Two serial streams come in: backplane data, and receive-side data that already shares the transmit timing. For every timeslot the block sends one of four things: the backplane data, a single idle code shared by all timeslots, a code kept separately for that timeslot, or the receive data looped back.

Settings arrive through a byte-wide write port. One 32-bit timeslot mask has a meaning that depends on a mode bit. With the mode bit clear, a set mask bit replaces the timeslot with the shared idle code. With the mode bit set, a set mask bit loops the receive data back into that timeslot. A second 32-bit enable mask, with 32 per-timeslot code registers, overwrites timeslots with their own codes, and it takes precedence over the first mask. The block latches its choice at the first bit of each timeslot, so a timeslot never goes out as a mix of old and new settings. The serial output is registered.

Top module: `e1_code_insert_mux`

## Requirements
- R1: While reset is high, and on the first edge after it, tx_data is 0. All masks, the mode bit, the idle code and the per-timeslot codes reset to zero, so after reset every timeslot carries backplane data.
- R2: A high fsync marks bit 0 of timeslot 1 in that same clock cycle. Without fsync, the bit position advances by one each clock and wraps from bit 7 of timeslot 32 to bit 0 of timeslot 1 after 256 clocks.
- R3: Addresses 0 to 3 hold the timeslot mask. Bit j of the byte at address k controls timeslot 8k+j+1.
- R4: When the mode bit is 0 and the mask bit of a timeslot is 1, the timeslot carries the shared idle code from address 5, sent MSB first: bit 7 in the first bit time and bit 0 in the last.
- R5: The mode bit is bit 0 of address 4. When it is 1, a timeslot whose mask bit is 1 carries rx_data bit for bit, and a timeslot whose mask bit is 0 carries bp_data.
- R6: Addresses 8 to 11 hold the code-enable mask, mapped to timeslots in the same way as R3. Address 32+n holds the code for timeslot n+1. An enabled timeslot carries its own code, MSB first.
- R7: When the code-enable bit and the mask bit of a timeslot are both 1, the per-timeslot code is sent, in either mode.
- R8: A write takes effect only from the next timeslot that starts after the write cycle. A write made during a timeslot does not change that timeslot's output.
- R9: tx_data carries the bit chosen in a clock cycle after the rising edge that ends that cycle, a fixed latency of one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame-sync pulse, high in the first bit time of timeslot 1 |
| bp_data | input | 1 | Backplane serial data |
| rx_data | input | 1 | Receive-side serial data aligned to transmit timing |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| tx_data | output | 1 | Registered serial output |

## Verification
The bench builds the block with its default parameters: 32 timeslots of 8 bits, so a frame is 256 clocks. At that size, whole frames, the wrap from timeslot 32 back to timeslot 1 and a fsync that lands mid-frame all fit in short runs, and every bit of every timeslot is compared against a reference model kept in the bench. Writes are also issued in the middle of a timeslot, which shows the boundary latching of R8 bit by bit.

// File: rtl/e1_mux_pkg.sv
package e1_mux_pkg;

    localparam int ADDR_W       = 6;
    localparam int CODE_W       = 8;
    localparam int ADDR_MASK0   = 0;
    localparam int ADDR_MODE    = 4;
    localparam int ADDR_IDLE    = 5;
    localparam int ADDR_CEN0    = 8;
    localparam int ADDR_CODE0   = 32;

    typedef enum logic [1:0] {
        SRC_BP   = 2'd0,
        SRC_IDLE = 2'd1,
        SRC_CODE = 2'd2,
        SRC_LOOP = 2'd3
    } src_e;

    typedef struct packed {
        src_e              src;
        logic [CODE_W-1:0] code;
    } slot_t;

    function automatic src_e pick_src(input logic cen, input logic msk, input logic loop_mode);
        if (cen)
            return SRC_CODE;
        else if (msk)
            return loop_mode ? SRC_LOOP : SRC_IDLE;
        else
            return SRC_BP;
    endfunction

endpackage

// File: rtl/e1_slot_timer.sv
module e1_slot_timer #(
    parameter int NUM_CH  = 32,
    parameter int CH_BITS = 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int BIT_W  = $clog2(CH_BITS),
    localparam int POS_W  = CH_W + BIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fsync,
    output logic [CH_W-1:0]  ch_idx,
    output logic [BIT_W-1:0] bit_idx
);
    logic [POS_W-1:0] cnt_q;
    logic [POS_W-1:0] pos_cur;

    assign pos_cur = fsync ? '0 : cnt_q;
    assign ch_idx  = pos_cur[POS_W-1:BIT_W];
    assign bit_idx = pos_cur[BIT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= pos_cur + POS_W'(1);
    end

    // R2: fsync places the next bit time at position 1
    a_r2_fsync_origin: assert property (@(posedge clk) disable iff (rst)
        fsync |=> (cnt_q == POS_W'(1)));

    // R2: free running advance with wrap
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (!fsync && !$past(rst)) |=> (cnt_q == $past(cnt_q) + POS_W'(1)));

endmodule

// File: rtl/e1_cfg_regs.sv
module e1_cfg_regs
    import e1_mux_pkg::*;
#(
    parameter int NUM_CH  = 32,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int BYTES  = NUM_CH / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] cen,
    output logic              loop_mode,
    output logic [CODE_W-1:0] idle_code,
    output logic [CODE_W-1:0] rd_code
);
    logic [CODE_W-1:0] code_q [NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask      <= '0;
            cen       <= '0;
            loop_mode <= 1'b0;
            idle_code <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < BYTES; k++) begin
                if (int'(wr_addr) == ADDR_MASK0 + k) mask[8*k +: 8] <= wr_data;
                if (int'(wr_addr) == ADDR_CEN0 + k)  cen[8*k +: 8]  <= wr_data;
            end
            if (int'(wr_addr) == ADDR_MODE) loop_mode <= wr_data[0];
            if (int'(wr_addr) == ADDR_IDLE) idle_code <= wr_data;
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_code
        always_ff @(posedge clk) begin
            if (rst)
                code_q[n] <= '0;
            else if (wr_en && int'(wr_addr) == ADDR_CODE0 + n)
                code_q[n] <= wr_data;
        end
    end

    assign rd_code = code_q[rd_ch];

endmodule

// File: rtl/e1_slot_select.sv
module e1_slot_select
    import e1_mux_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int CH_BITS = 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int BIT_W  = $clog2(CH_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH_W-1:0]   ch_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [NUM_CH-1:0] mask,
    input  logic [NUM_CH-1:0] cen,
    input  logic              loop_mode,
    input  logic [CODE_W-1:0] idle_code,
    input  logic [CODE_W-1:0] ch_code,
    input  logic              bp_data,
    input  logic              rx_data,
    output src_e              cur_src,
    output logic              sel_bit
);
    slot_t slot_q;
    slot_t slot_new;
    slot_t slot_cur;
    logic  start;

    assign start        = (bit_idx == '0);
    assign slot_new.src  = pick_src(cen[ch_idx], mask[ch_idx], loop_mode);
    assign slot_new.code = cen[ch_idx] ? ch_code : idle_code;
    assign slot_cur      = start ? slot_new : slot_q;
    assign cur_src       = slot_cur.src;

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '{src: SRC_BP, code: '0};
        else
            slot_q <= slot_cur;
    end

    always_comb begin
        unique case (slot_cur.src)
            SRC_BP:   sel_bit = bp_data;
            SRC_LOOP: sel_bit = rx_data;
            default:  sel_bit = slot_cur.code[BIT_W'(CH_BITS-1) - bit_idx];
        endcase
    end

    // R8: the latched choice only moves at a timeslot start
    a_r8_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (!start) |=> $stable(slot_q));

    // R7: an enabled per-timeslot code wins over the mask
    a_r7_code_wins: assert property (@(posedge clk) disable iff (rst)
        (start && cen[ch_idx]) |=> (slot_q.src == SRC_CODE));

endmodule

// File: rtl/e1_code_insert_mux.sv
module e1_code_insert_mux
    import e1_mux_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int CH_BITS = CODE_W,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int BIT_W  = $clog2(CH_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fsync,
    input  logic              bp_data,
    input  logic              rx_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              tx_data
);
    logic [CH_W-1:0]   ch_idx;
    logic [BIT_W-1:0]  bit_idx;
    logic [NUM_CH-1:0] mask;
    logic [NUM_CH-1:0] cen;
    logic              loop_mode;
    logic [CODE_W-1:0] idle_code;
    logic [CODE_W-1:0] ch_code;
    src_e              cur_src;
    logic              sel_bit;

    e1_slot_timer #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_timer (
        .clk(clk), .rst(rst), .fsync(fsync),
        .ch_idx(ch_idx), .bit_idx(bit_idx)
    );

    e1_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_ch(ch_idx),
        .mask(mask), .cen(cen), .loop_mode(loop_mode),
        .idle_code(idle_code), .rd_code(ch_code)
    );

    e1_slot_select #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_sel (
        .clk(clk), .rst(rst),
        .ch_idx(ch_idx), .bit_idx(bit_idx),
        .mask(mask), .cen(cen), .loop_mode(loop_mode),
        .idle_code(idle_code), .ch_code(ch_code),
        .bp_data(bp_data), .rx_data(rx_data),
        .cur_src(cur_src), .sel_bit(sel_bit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tx_data <= 1'b0;
        else
            tx_data <= sel_bit;
    end

    // R5: a looped timeslot repeats rx_data one clock later
    a_r5_loop_path: assert property (@(posedge clk) disable iff (rst)
        (cur_src == SRC_LOOP) |=> (tx_data == $past(rx_data)));

    // R9: a backplane timeslot repeats bp_data one clock later
    a_r9_bp_path: assert property (@(posedge clk) disable iff (rst)
        (cur_src == SRC_BP) |=> (tx_data == $past(bp_data)));

    // R1: output held low in reset
    a_r1_reset_low: assert property (@(posedge clk)
        $past(rst) |-> (tx_data == 1'b0));

endmodule

// File: tb/e1_code_insert_mux_test.sv
module e1_code_insert_mux_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0;
    logic       bp_data = 1'b0;
    logic       rx_data = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    e1_code_insert_mux uut (
        .clk(clk), .rst(rst), .fsync(fsync), .bp_data(bp_data), .rx_data(rx_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tx_data(tx_data)
    );

    // reference model state
    logic [31:0] m_mask = '0;
    logic [31:0] m_cen  = '0;
    logic        m_mode = 1'b0;
    logic [7:0]  m_idle = '0;
    logic [7:0]  m_code [32];
    int          m_src  = 0;
    logic [7:0]  m_val  = '0;
    int          mpos   = 0;
    int          cyc    = 0;
    logic        exp_prev = 1'b0;
    bit          exp_valid = 1'b0;
    string       prev_tag = "";
    int          prev_ch = 0;
    int          prev_b = 0;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: tx_data=%b expected %b (timeslot %0d bit %0d)",
                     tag, act, exp, prev_ch + 1, prev_b);
        end
    endtask

    task automatic tick(input logic fs, input logic we, input logic [5:0] wa,
                        input logic [7:0] wd, input string tag);
        int pos, ch, b;
        logic bpv, rxv, e;
        @(negedge clk);
        if (exp_valid) check(tx_data, exp_prev, prev_tag);
        pos = fs ? 0 : mpos;
        ch  = pos / 8;
        b   = pos % 8;
        bpv = cyc[0] ^ cyc[3] ^ cyc[5];
        rxv = ~(cyc[1] ^ cyc[2] ^ cyc[6]);
        if (b == 0) begin
            if (m_cen[ch])       begin m_src = 2; m_val = m_code[ch]; end
            else if (m_mask[ch]) begin m_src = m_mode ? 3 : 1; m_val = m_idle; end
            else                 m_src = 0;
        end
        case (m_src)
            0:       e = bpv;
            3:       e = rxv;
            default: e = m_val[7-b];
        endcase
        fsync = fs; bp_data = bpv; rx_data = rxv;
        wr_en = we; wr_addr = wa; wr_data = wd;
        if (we) begin
            if (wa < 4)                 m_mask[8*wa +: 8] = wd;
            else if (wa == 4)           m_mode = wd[0];
            else if (wa == 5)           m_idle = wd;
            else if (wa >= 8 && wa < 12) m_cen[8*(wa-8) +: 8] = wd;
            else if (wa >= 32)          m_code[wa-32] = wd;
        end
        exp_prev = e; exp_valid = 1'b1; prev_tag = tag; prev_ch = ch; prev_b = b;
        mpos = (pos + 1) % 256;
        cyc++;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, '0, '0, tag);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d, input string tag);
        tick(1'b0, 1'b1, a, d, tag);
    endtask

    task automatic frame(input string tag);
        tick(1'b1, 1'b0, '0, '0, tag);
        run(263, tag);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 32; i++) m_code[i] = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        checks++;
        if (tx_data !== 1'b0) begin
            errors++;
            $display("FAIL R1: tx_data=%b expected 0 during reset", tx_data);
        end
        rst = 1'b0;
        exp_valid = 1'b0;
        frame("R1 backplane after reset / R9 latency");
    endtask

    task automatic t_idle;
        wr(6'd0, 8'h81, "R3");
        wr(6'd1, 8'h00, "R3");
        wr(6'd2, 8'h20, "R3");
        wr(6'd3, 8'h80, "R3");
        wr(6'd4, 8'h00, "R4");
        wr(6'd5, 8'hA5, "R4");
        frame("R3 mask mapping / R4 idle code MSB first");
    endtask

    task automatic t_loop;
        wr(6'd4, 8'h01, "R5");
        frame("R5 loopback of rx_data");
    endtask

    task automatic t_codes;
        for (int k = 0; k < 4; k++) wr(6'(k), 8'h00, "R6");
        wr(6'd8,  8'h0F, "R6");
        wr(6'd9,  8'hF0, "R6");
        wr(6'd10, 8'h3C, "R6");
        wr(6'd11, 8'h81, "R6");
        for (int n = 0; n < 32; n++) wr(6'(32 + n), 8'(n * 37 + 11), "R6");
        frame("R6 per-timeslot codes");
    endtask

    task automatic t_priority;
        for (int k = 0; k < 4; k++) wr(6'(k), 8'hFF, "R7");
        wr(6'd4, 8'h00, "R7");
        wr(6'd5, 8'h5A, "R7");
        frame("R7 code over idle");
        wr(6'd4, 8'h01, "R7");
        frame("R7 code over loopback");
    endtask

    task automatic t_midwrite;
        for (int k = 0; k < 4; k++) wr(6'(8 + k), 8'h00, "R8");
        for (int k = 0; k < 4; k++) wr(6'(k), 8'h00, "R8");
        wr(6'd0, 8'h08, "R8");
        wr(6'd4, 8'h00, "R8");
        wr(6'd5, 8'hA5, "R8");
        tick(1'b1, 1'b0, '0, '0, "R8 write inside a timeslot");
        run(27, "R8 write inside a timeslot");
        wr(6'd5, 8'h3C, "R8 write inside a timeslot");
        wr(6'd0, 8'h10, "R8 write inside a timeslot");
        wr(6'd9, 8'h01, "R8 write inside a timeslot");
        run(240, "R8 write inside a timeslot");
    endtask

    task automatic t_wrap;
        for (int k = 0; k < 4; k++) wr(6'(k), 8'h96, "R2");
        wr(6'd4, 8'h00, "R2");
        tick(1'b1, 1'b0, '0, '0, "R2 wrap after 256 clocks");
        run(600, "R2 wrap after 256 clocks");
        tick(1'b1, 1'b0, '0, '0, "R2 fsync mid-frame");
        run(77, "R2 fsync mid-frame");
        tick(1'b1, 1'b0, '0, '0, "R2 fsync mid-timeslot");
        run(120, "R2 fsync mid-timeslot");
    endtask

    initial begin
        t_reset;
        t_idle;
        t_loop;
        t_codes;
        t_priority;
        t_midwrite;
        t_wrap;
        @(negedge clk);
        check(tx_data, exp_prev, prev_tag);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule